// File: doc/BRIEF.md
# Processor Power State Controller

This block follows the power-management state of a processor core, one clock at a time. It tracks six states: running, halted after a halt instruction, stop granted, clock stopped, a short snoop wake-up, and a cache flush. It changes state on strobes and levels from the core and the system. These inputs are a halt strobe, an active-low stop-clock request, a clock-running level, the wake sources, an external snoop strobe with its modified-hit flag, a write-back-done strobe and a flush request and completion. The block does not gate any clock. A stopped clock is signalled on `clk_run_i`, and the block keeps running so that it can see the restart.

On some transitions the block raises a one-cycle request for a special bus cycle: halt, stop grant or flush acknowledge. These requests depend on the path taken. Entering stop grant from running or halted raises the stop-grant request. Coming back to stop grant from the clock-stopped or snoop states raises nothing. Leaving stop grant back to halted raises a fresh halt request. Two return-state registers remember where stop grant and the snoop or flush detours began. A HITM flag covers the write-back of a modified line during a snoop. A core-powered level tells the system whether the core logic is awake.

Top module: `pwr_state_ctl`

## Requirements
- R1: `state_o` encodes running=0, halted=1, stop-grant=2, clock-stopped=3, snoop=4, flush=5. After `rst_n` is asserted, or one cycle after `reset_i` is sampled high in any state, the state is running, all bus-cycle requests and `hitm_o` are 0, and both saved return states are cleared to running.
- R2: In running, a `halt_i` strobe moves to halted. In the same cycle that `state_o` shows halted, `halt_cyc_o` is 1 for exactly one cycle.
- R3: Halted stays halted until `intr_i`, `nmi_i`, `smi_i` or `sreset_i` is sampled high. Any one of these moves it to running. A snoop strobe in running is ignored.
- R4: A low `stpclk_n_i` in running or halted enters stop-grant and raises `sgnt_cyc_o` for one cycle. In running, a stop-clock request wins over a flush request, and a flush request wins over halt. In halted, a wake source wins over the stop-clock request.
- R5: In stop-grant, a high `stpclk_n_i` returns to the state that stop-grant was entered from. If that state was halted, `halt_cyc_o` pulses once. If it was running, no request pulses.
- R6: In stop-grant, `clk_run_i` low moves to clock-stopped. In clock-stopped, `clk_run_i` high returns to stop-grant with no `sgnt_cyc_o` pulse.
- R7: A `snoop_i` strobe in stop-grant or halted enters snoop. Without a modified hit, the snoop lasts exactly one cycle and then returns to the prior state. No request pulses on that return.
- R8: If `mod_hit_i` is high with the snoop strobe, `hitm_o` is 1 from the snoop cycle on, and snoop is held. Both end one cycle after `wb_done_i` is sampled high, and the block returns to the prior state.
- R9: `flush_req_i` enters flush from running or halted only when `wb_mode_i` is 1. On `flush_done_i`, the block returns to the prior state and `flush_cyc_o` pulses once.
- R10: `core_pwr_o` is 0 in stop-grant and clock-stopped, and 1 in every other state.
- R11: An `intr_i` raised in clock-stopped and held takes the block back through stop-grant to halted, and from there to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe |
| stpclk_n_i | input | 1 | Stop-clock request, active low |
| clk_run_i | input | 1 | High while the core clock runs |
| intr_i | input | 1 | Maskable interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| smi_i | input | 1 | System-management interrupt |
| reset_i | input | 1 | Synchronous hard reset request |
| sreset_i | input | 1 | Soft reset |
| snoop_i | input | 1 | External snoop strobe |
| mod_hit_i | input | 1 | Snoop hit a modified line |
| wb_done_i | input | 1 | Snoop write-back finished |
| flush_req_i | input | 1 | Cache flush request |
| flush_done_i | input | 1 | Cache flush finished |
| wb_mode_i | input | 1 | Write-back cache mode enabled |
| state_o | output | 3 | Current power state |
| halt_cyc_o | output | 1 | One-cycle halt bus-cycle request |
| sgnt_cyc_o | output | 1 | One-cycle stop-grant bus-cycle request |
| flush_cyc_o | output | 1 | One-cycle flush bus-cycle request |
| hitm_o | output | 1 | Modified-line hit indication |
| core_pwr_o | output | 1 | Core logic powered |

## Verification
Every input is sampled on one rising edge. The new state, every bus-cycle request and `hitm_o` appear right after that edge, with no further delay. `core_pwr_o` follows the state within the same cycle. The bench changes inputs one time unit after a rising edge and advances one edge. It checks just after that edge, so each expected value belongs to the edge that produced it. The check one edge later confirms that every request pulse has dropped.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_SGNT  = 3'd2,
    PS_SCLK  = 3'd3,
    PS_SNOOP = 3'd4,
    PS_FLUSH = 3'd5
  } pstate_t;

  typedef struct packed {
    logic halt;
    logic sgnt;
    logic flush;
  } busreq_t;

  localparam busreq_t BUSREQ_NONE = '{halt: 1'b0, sgnt: 1'b0, flush: 1'b0};
endpackage

// File: rtl/pwr_next_state.sv
module pwr_next_state
  import pwr_state_pkg::*;
(
  input  pstate_t st_q,
  input  pstate_t sg_ret_q,
  input  pstate_t aux_ret_q,
  input  logic    hitm_q,
  input  logic    halt_i,
  input  logic    stpclk_n_i,
  input  logic    clk_run_i,
  input  logic    wake_i,
  input  logic    reset_i,
  input  logic    snoop_i,
  input  logic    wb_done_i,
  input  logic    flush_ok_i,
  input  logic    flush_done_i,
  output pstate_t st_d,
  output pstate_t sg_ret_d,
  output pstate_t aux_ret_d,
  output busreq_t req_d,
  output logic    snoop_enter
);
  always_comb begin
    st_d        = st_q;
    sg_ret_d    = sg_ret_q;
    aux_ret_d   = aux_ret_q;
    req_d       = BUSREQ_NONE;
    snoop_enter = 1'b0;
    if (reset_i) begin
      st_d      = PS_RUN;
      sg_ret_d  = PS_RUN;
      aux_ret_d = PS_RUN;
    end else begin
      unique case (st_q)
        PS_RUN: begin
          if (!stpclk_n_i) begin
            st_d       = PS_SGNT;
            sg_ret_d   = PS_RUN;
            req_d.sgnt = 1'b1;
          end else if (flush_ok_i) begin
            st_d      = PS_FLUSH;
            aux_ret_d = PS_RUN;
          end else if (halt_i) begin
            st_d       = PS_HALT;
            req_d.halt = 1'b1;
          end
        end
        PS_HALT: begin
          if (wake_i) begin
            st_d = PS_RUN;
          end else if (!stpclk_n_i) begin
            st_d       = PS_SGNT;
            sg_ret_d   = PS_HALT;
            req_d.sgnt = 1'b1;
          end else if (snoop_i) begin
            st_d        = PS_SNOOP;
            aux_ret_d   = PS_HALT;
            snoop_enter = 1'b1;
          end else if (flush_ok_i) begin
            st_d      = PS_FLUSH;
            aux_ret_d = PS_HALT;
          end
        end
        PS_SGNT: begin
          if (!clk_run_i) begin
            st_d = PS_SCLK;
          end else if (snoop_i) begin
            st_d        = PS_SNOOP;
            aux_ret_d   = PS_SGNT;
            snoop_enter = 1'b1;
          end else if (stpclk_n_i) begin
            st_d       = sg_ret_q;
            req_d.halt = (sg_ret_q == PS_HALT);
          end
        end
        PS_SCLK: begin
          if (clk_run_i) st_d = PS_SGNT;
        end
        PS_SNOOP: begin
          if (!hitm_q || wb_done_i) st_d = aux_ret_q;
        end
        PS_FLUSH: begin
          if (flush_done_i) begin
            st_d        = aux_ret_q;
            req_d.flush = 1'b1;
          end
        end
        default: st_d = PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_hitm_trk.sv
module pwr_hitm_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_i,
  input  logic snoop_enter,
  input  logic mod_hit_i,
  input  logic wb_done_i,
  output logic hitm_q
);
  logic hitm_d;
  logic hitm_en;

  always_comb begin
    hitm_en = reset_i || (snoop_enter && mod_hit_i) || (hitm_q && wb_done_i);
    hitm_d  = !reset_i && snoop_enter && mod_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hitm_q <= 1'b0;
    else if (hitm_en) hitm_q <= hitm_d;
  end
endmodule

// File: rtl/pwr_state_regs.sv
module pwr_state_regs
  import pwr_state_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t st_d,
  input  pstate_t sg_ret_d,
  input  pstate_t aux_ret_d,
  input  busreq_t req_d,
  output pstate_t st_q,
  output pstate_t sg_ret_q,
  output pstate_t aux_ret_q,
  output busreq_t req_q
);
  logic st_en;
  logic ret_en;

  always_comb begin
    st_en  = (st_d != st_q);
    ret_en = (sg_ret_d != sg_ret_q) || (aux_ret_d != aux_ret_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= PS_RUN;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sg_ret_q  <= PS_RUN;
      aux_ret_q <= PS_RUN;
    end else if (ret_en) begin
      sg_ret_q  <= sg_ret_d;
      aux_ret_q <= aux_ret_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= BUSREQ_NONE;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwr_state_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_i,
  input  logic               stpclk_n_i,
  input  logic               clk_run_i,
  input  logic               intr_i,
  input  logic               nmi_i,
  input  logic               smi_i,
  input  logic               reset_i,
  input  logic               sreset_i,
  input  logic               snoop_i,
  input  logic               mod_hit_i,
  input  logic               wb_done_i,
  input  logic               flush_req_i,
  input  logic               flush_done_i,
  input  logic               wb_mode_i,
  output logic [STATE_W-1:0] state_o,
  output logic               halt_cyc_o,
  output logic               sgnt_cyc_o,
  output logic               flush_cyc_o,
  output logic               hitm_o,
  output logic               core_pwr_o
);
  pstate_t st_q, st_d, sg_ret_q, sg_ret_d, aux_ret_q, aux_ret_d;
  busreq_t req_d, req_q;
  logic    hitm_q, snoop_enter, wake, flush_ok;

  always_comb begin
    wake     = intr_i || nmi_i || smi_i || sreset_i;
    flush_ok = flush_req_i && wb_mode_i;
  end

  pwr_next_state u_next (
    .st_q(st_q), .sg_ret_q(sg_ret_q), .aux_ret_q(aux_ret_q), .hitm_q(hitm_q),
    .halt_i(halt_i), .stpclk_n_i(stpclk_n_i), .clk_run_i(clk_run_i),
    .wake_i(wake), .reset_i(reset_i), .snoop_i(snoop_i), .wb_done_i(wb_done_i),
    .flush_ok_i(flush_ok), .flush_done_i(flush_done_i),
    .st_d(st_d), .sg_ret_d(sg_ret_d), .aux_ret_d(aux_ret_d), .req_d(req_d),
    .snoop_enter(snoop_enter)
  );

  pwr_state_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .st_d(st_d), .sg_ret_d(sg_ret_d), .aux_ret_d(aux_ret_d), .req_d(req_d),
    .st_q(st_q), .sg_ret_q(sg_ret_q), .aux_ret_q(aux_ret_q), .req_q(req_q)
  );

  pwr_hitm_trk u_hitm (
    .clk(clk), .rst_n(rst_n), .reset_i(reset_i), .snoop_enter(snoop_enter),
    .mod_hit_i(mod_hit_i), .wb_done_i(wb_done_i), .hitm_q(hitm_q)
  );

  always_comb begin
    state_o     = st_q;
    halt_cyc_o  = req_q.halt;
    sgnt_cyc_o  = req_q.sgnt;
    flush_cyc_o = req_q.flush;
    hitm_o      = hitm_q;
    core_pwr_o  = !((st_q == PS_SGNT) || (st_q == PS_SCLK));
  end
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk
  import pwr_state_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reset_i,
  input logic               clk_run_i,
  input logic               wb_done_i,
  input logic [STATE_W-1:0] state_o,
  input logic               halt_cyc_o,
  input logic               sgnt_cyc_o,
  input logic               flush_cyc_o,
  input logic               hitm_o,
  input logic               core_pwr_o
);
  // R1
  reset_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_i |=> (state_o == PS_RUN) && !hitm_o && !halt_cyc_o && !sgnt_cyc_o && !flush_cyc_o);

  // R4
  sgnt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sgnt_cyc_o |-> (state_o == PS_SGNT) &&
                   (($past(state_o) == PS_RUN) || ($past(state_o) == PS_HALT)));

  // R6
  sclk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_SCLK) && !reset_i && !clk_run_i |=> (state_o == PS_SCLK));

  // R7
  snoop_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == PS_SNOOP) && !hitm_o && !reset_i |=>
      (state_o != PS_SNOOP) && !halt_cyc_o && !sgnt_cyc_o && !flush_cyc_o);

  // R8
  hitm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hitm_o && !wb_done_i && !reset_i |=> hitm_o && (state_o == PS_SNOOP));

  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cyc_o |-> ($past(state_o) == PS_FLUSH));

  // R2
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_cyc_o, sgnt_cyc_o, flush_cyc_o}));

  // R10
  pwr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_o |-> (state_o == PS_SGNT) || (state_o == PS_SCLK));
endmodule

bind pwr_state_ctl pwr_state_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reset_i(reset_i), .clk_run_i(clk_run_i),
  .wb_done_i(wb_done_i), .state_o(state_o), .halt_cyc_o(halt_cyc_o),
  .sgnt_cyc_o(sgnt_cyc_o), .flush_cyc_o(flush_cyc_o), .hitm_o(hitm_o),
  .core_pwr_o(core_pwr_o)
);

// File: tb/pwr_state_ctl_tb.sv
module pwr_state_ctl_tb;
  localparam logic [2:0] S_RUN = 3'd0, S_HALT = 3'd1, S_SGNT = 3'd2,
                         S_SCLK = 3'd3, S_SNOOP = 3'd4, S_FLUSH = 3'd5;

  logic clk = 1'b0;
  logic rst_n, halt_i, stpclk_n_i, clk_run_i, intr_i, nmi_i, smi_i, reset_i;
  logic sreset_i, snoop_i, mod_hit_i, wb_done_i, flush_req_i, flush_done_i, wb_mode_i;
  logic [2:0] state_o;
  logic halt_cyc_o, sgnt_cyc_o, flush_cyc_o, hitm_o, core_pwr_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  pwr_state_ctl u_dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    halt_i = 0; stpclk_n_i = 1; clk_run_i = 1; intr_i = 0; nmi_i = 0; smi_i = 0;
    reset_i = 0; sreset_i = 0; snoop_i = 0; mod_hit_i = 0; wb_done_i = 0;
    flush_req_i = 0; flush_done_i = 0;
  endtask

  task automatic to_run();
    idle(); reset_i = 1; step(); reset_i = 0;
  endtask

  task automatic to_halt();
    to_run(); halt_i = 1; step(); halt_i = 0;
  endtask

  task automatic chk_req(input string tag, input int h, input int s, input int f);
    chk({tag, " halt_cyc"}, halt_cyc_o, h);
    chk({tag, " sgnt_cyc"}, sgnt_cyc_o, s);
    chk({tag, " flush_cyc"}, flush_cyc_o, f);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(); wb_mode_i = 1; rst_n = 0;
    step(); step();
    // R1 reset state
    chk("R1 state", state_o, S_RUN);
    chk_req("R1", 0, 0, 0);
    chk("R1 hitm", hitm_o, 0);
    chk("R10 pwr", core_pwr_o, 1);
    rst_n = 1; step();

    // R2 halt entry and single pulse
    halt_i = 1; step(); halt_i = 0;
    chk("R2 state", state_o, S_HALT);
    chk_req("R2", 1, 0, 0);
    step();
    chk_req("R2 drop", 0, 0, 0);

    // R3 wake sweep
    for (int src = 0; src < 4; src++) begin
      to_halt();
      step(); step();
      chk("R3 hold", state_o, S_HALT);
      intr_i = (src == 0); nmi_i = (src == 1); smi_i = (src == 2); sreset_i = (src == 3);
      step(); idle();
      chk("R3 wake", state_o, S_RUN);
    end
    to_run(); snoop_i = 1; step(); snoop_i = 0;
    chk("R3 snoop ignored in run", state_o, S_RUN);

    // R4 / R5 from run, with priority over flush and halt
    to_run(); stpclk_n_i = 0; halt_i = 1; flush_req_i = 1; step();
    halt_i = 0; flush_req_i = 0;
    chk("R4 state", state_o, S_SGNT);
    chk_req("R4", 0, 1, 0);
    chk("R10 pwr sg", core_pwr_o, 0);
    step(); chk_req("R4 drop", 0, 0, 0);
    stpclk_n_i = 1; step();
    chk("R5 back run", state_o, S_RUN);
    chk_req("R5 run", 0, 0, 0);
    // R4 flush beats halt in run
    flush_req_i = 1; halt_i = 1; step(); idle();
    chk("R4 flush over halt", state_o, S_FLUSH);

    // R4 wake beats stop clock in halt
    to_halt(); stpclk_n_i = 0; nmi_i = 1; step(); idle();
    chk("R4 wake over stpclk", state_o, S_RUN);

    // R4 / R5 / R6 from halt
    to_halt(); stpclk_n_i = 0; step();
    chk("R4 halt->sg", state_o, S_SGNT);
    chk_req("R4 halt", 0, 1, 0);
    clk_run_i = 0; step();
    chk("R6 sclk", state_o, S_SCLK);
    chk("R10 pwr sclk", core_pwr_o, 0);
    step(); chk("R6 stay", state_o, S_SCLK);
    clk_run_i = 1; step();
    chk("R6 back sg", state_o, S_SGNT);
    chk_req("R6", 0, 0, 0);
    // R7 snoop from sg, no hit
    snoop_i = 1; step(); snoop_i = 0;
    chk("R7 snoop", state_o, S_SNOOP);
    chk("R10 pwr snoop", core_pwr_o, 1);
    chk("R8 no hitm", hitm_o, 0);
    step();
    chk("R7 return sg", state_o, S_SGNT);
    chk_req("R7", 0, 0, 0);
    stpclk_n_i = 1; step();
    chk("R5 back halt", state_o, S_HALT);
    chk_req("R5 halt", 1, 0, 0);

    // R8 modified hit from halt
    to_halt(); snoop_i = 1; mod_hit_i = 1; step(); snoop_i = 0; mod_hit_i = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R8 hold state", state_o, S_SNOOP);
      chk("R8 hitm", hitm_o, 1);
      step();
    end
    wb_done_i = 1; step(); wb_done_i = 0;
    chk("R8 return", state_o, S_HALT);
    chk("R8 hitm clr", hitm_o, 0);
    chk_req("R8", 0, 0, 0);

    // R9 flush sweep
    for (int wb = 0; wb < 2; wb++) begin
      for (int from = 0; from < 2; from++) begin
        if (from == 0) to_run(); else to_halt();
        wb_mode_i = wb[0]; flush_req_i = 1; step(); flush_req_i = 0;
        chk("R9 entry", state_o, (wb == 1) ? S_FLUSH : from);
        if (wb == 1) begin
          step(); chk("R9 wait", state_o, S_FLUSH);
          flush_done_i = 1; step(); flush_done_i = 0;
          chk("R9 return", state_o, from);
          chk_req("R9", 0, 0, 1);
          step(); chk_req("R9 drop", 0, 0, 0);
        end
      end
    end
    wb_mode_i = 1;

    // R11 interrupt held while clock is stopped
    to_halt(); stpclk_n_i = 0; step(); clk_run_i = 0; step();
    intr_i = 1; step();
    chk("R11 stays sclk", state_o, S_SCLK);
    clk_run_i = 1; step();
    chk("R11 sg", state_o, S_SGNT);
    stpclk_n_i = 1; step();
    chk("R11 halt", state_o, S_HALT);
    step();
    chk("R11 run", state_o, S_RUN);
    idle();

    // R1 reset from clock stopped clears saved return
    to_halt(); stpclk_n_i = 0; step(); clk_run_i = 0; step();
    reset_i = 1; step(); reset_i = 0; clk_run_i = 1;
    chk("R1 reset sclk", state_o, S_RUN);
    step(); chk("R1 restart sg", state_o, S_SGNT);
    stpclk_n_i = 1; step();
    chk("R1 ret cleared", state_o, S_RUN);
    chk_req("R1 ret", 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule